// File: doc/BRIEF.md
# Double-Buffered Capture Address Controller

This block decides where incoming capture words land in memory. Each accepted word goes to the current buffer address, and that address then advances by four bytes. A word counter tracks progress through the buffer against a length that software programs in 32-bit words. When the last word of a buffer has been accepted by memory, the block flags the fill. It then moves to a pending next-buffer address at once, so software has a whole buffer period to supply the address that follows.

Software drives the block through a small register port. The first write to the base register after reset names the current buffer. Later writes fill the shadow slot. An 8-bit status register collects the fill, the stall and five external event sources. Each status bit has an enable bit in a matching mask, status bits clear when software writes ones to them, and the enabled bits are combined onto one interrupt line. A run bit gates capture. A self-clearing soft-reset bit returns every register to its reset value.

Top module: `capture_addr_ctrl`

## Requirements
- R1: The buffer length register (index 3) counts 32-bit words. After exactly that many accepted words (memValid and memReady high together), status bit 7 (transfer done) and status bit 6 (buffer full) are both set.
- R2: Within a buffer, the n-th accepted word (counting from 0) is written to memAddr = base + 4*n.
- R3: After reset, the first write to the base register (index 2) sets the current address, read back at index 2. A later write sets the shadow, read back at index 7. Index 8 reads {shadowValid, currentValid} in bits 1:0.
- R4: When a buffer fills while a shadow is valid, the next word goes to the shadow address and the shadow slot becomes empty.
- R5: When a buffer fills with no shadow, capture stalls (capReady and memValid low) and status bit 5 is set. The next base write resumes capture at the address written.
- R6: Writing the status register (index 4) clears the bits written as 1 and leaves the bits written as 0 unchanged. A set event wins over a clear in the same cycle.
- R7: The interrupt mask is at index 5, and irq is high exactly when status AND mask is nonzero. Writing 0xFF to the mask enables all eight sources.
- R8: Bit 0 of the run register (index 0) gates capture. While it is 0, memValid and capReady stay low.
- R9: Writing bit 31 of the control register (index 1) clears run, length, status, mask, both addresses and their valid flags. Index 1 always reads as 0.
- R10: A high extEvt[k] sets status bit k for k = 0..4: input error, clock timeout, size overflow, size underflow, sync mismatch.
- R11: memValid is high only while capValid is high. memData equals capData whenever memValid is high, and capReady is high only while memReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register index for write and read |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data (combinational from busAddr) |
| extEvt | input | 5 | External event sources for status bits 4:0 |
| capValid | input | 1 | Capture word available |
| capData | input | DATA_W | Capture word |
| capReady | output | 1 | Capture word taken this cycle |
| memValid | output | 1 | Memory write request |
| memAddr | output | ADDR_W | Byte address of the write |
| memData | output | DATA_W | Write data |
| memReady | input | 1 | Memory accepts the write |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with a 16-bit address and an 8-bit word counter. Short buffers of one to six words are then cheap to run, so it sweeps every length in that range. Each sweep uses a memory-ready pattern that holds back one cycle in three. For every accepted word, the bench computes the expected address arithmetically from the two programmed bases. Each sweep crosses one swap to the shadow and one stall with no shadow, and it checks resumption from a late base write. Single-length cases also cover status clearing, mask combinations, run gating, external events and soft reset.

// File: rtl/capaddr_pkg.sv
package capaddr_pkg;
  localparam int REG_RUN    = 0;
  localparam int REG_CTRL   = 1;
  localparam int REG_BASE   = 2;
  localparam int REG_SIZE   = 3;
  localparam int REG_STATUS = 4;
  localparam int REG_MASK   = 5;
  localparam int REG_CUR    = 6;
  localparam int REG_SHADOW = 7;
  localparam int REG_FLAGS  = 8;

  localparam int ST_DONE      = 7;
  localparam int ST_BUF_FULL  = 6;
  localparam int ST_STALL     = 5;
  localparam int EXT_EVT_W    = 5;
  localparam int SOFT_RST_BIT = 31;

  typedef struct packed {
    logic clrAll;
    logic baseWr;
    logic run;
  } dpStrobe_t;
endpackage

// File: rtl/capaddr_ctrl.sv
module capaddr_ctrl
  import capaddr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [3:0]           busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [EXT_EVT_W-1:0] extEvt,
  input  logic                 fillEvt,
  input  logic                 starveEvt,
  input  logic [ADDR_W-1:0]    activeBase,
  input  logic [ADDR_W-1:0]    shadowBase,
  input  logic [ADDR_W-1:0]    curAddr,
  input  logic [1:0]           flags,
  output dpStrobe_t            stb,
  output logic [CNT_W-1:0]     sizeWords,
  output logic [7:0]           statusReg,
  output logic [7:0]           maskReg,
  output logic                 irq
);
  logic       runBit;
  logic       softRst;
  logic [7:0] setVec;
  logic [7:0] clrVec;

  function automatic logic hit(input int idx);
    return busWrEn && (busAddr == 4'(idx));
  endfunction

  assign softRst = hit(REG_CTRL) && busWrData[SOFT_RST_BIT];
  assign setVec  = {fillEvt, fillEvt, starveEvt, extEvt};
  assign clrVec  = hit(REG_STATUS) ? busWrData[7:0] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit    <= 1'b0;
      sizeWords <= '0;
      statusReg <= '0;
      maskReg   <= '0;
    end else if (softRst) begin
      runBit    <= 1'b0;
      sizeWords <= '0;
      statusReg <= '0;
      maskReg   <= '0;
    end else begin
      if (hit(REG_RUN))  runBit    <= busWrData[0];
      if (hit(REG_SIZE)) sizeWords <= busWrData[CNT_W-1:0];
      if (hit(REG_MASK)) maskReg   <= busWrData[7:0];
      statusReg <= (statusReg & ~clrVec) | setVec;
    end
  end

  assign stb.clrAll = softRst;
  assign stb.baseWr = hit(REG_BASE);
  assign stb.run    = runBit;
  assign irq        = |(statusReg & maskReg);

  always_comb begin
    busRdData = '0;
    case (busAddr)
      4'(REG_RUN):    busRdData[0]        = runBit;
      4'(REG_BASE):   busRdData[ADDR_W-1:0] = activeBase;
      4'(REG_SIZE):   busRdData[CNT_W-1:0]  = sizeWords;
      4'(REG_STATUS): busRdData[7:0]      = statusReg;
      4'(REG_MASK):   busRdData[7:0]      = maskReg;
      4'(REG_CUR):    busRdData[ADDR_W-1:0] = curAddr;
      4'(REG_SHADOW): busRdData[ADDR_W-1:0] = shadowBase;
      4'(REG_FLAGS):  busRdData[1:0]      = flags;
      default:        busRdData = '0;
    endcase
  end
endmodule

// File: rtl/capaddr_dp.sv
module capaddr_dp
  import capaddr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] baseData,
  input  logic [CNT_W-1:0]  sizeWords,
  input  logic              capValid,
  input  logic [DATA_W-1:0] capData,
  output logic              capReady,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memReady,
  output logic              fillEvt,
  output logic              starveEvt,
  output logic [ADDR_W-1:0] activeBase,
  output logic [ADDR_W-1:0] shadowBase,
  output logic [1:0]        flags
);
  localparam int OFS_W = CNT_W + 2;

  logic              activeValid, shadowValid;
  logic [CNT_W-1:0]  wordCnt;
  logic              accept, lastWord, open;
  logic              nActV, nShV;
  logic [ADDR_W-1:0] nActB, nShB;
  logic [CNT_W-1:0]  nCnt;

  assign open      = stb.run && activeValid;
  assign memValid  = open && capValid;
  assign capReady  = open && memReady;
  assign memData   = capData;
  assign memAddr   = activeBase + ADDR_W'({wordCnt, 2'b00});
  assign accept    = memValid && memReady;
  assign lastWord  = accept && ((wordCnt + 1'b1) == sizeWords);
  assign fillEvt   = lastWord;
  assign starveEvt = lastWord && !shadowValid;
  assign flags     = {shadowValid, activeValid};

  always_comb begin
    nActV = activeValid;
    nShV  = shadowValid;
    nActB = activeBase;
    nShB  = shadowBase;
    nCnt  = wordCnt;
    if (accept) begin
      if (lastWord) begin
        nCnt = '0;
        if (shadowValid) begin
          nActB = shadowBase;
          nShV  = 1'b0;
        end else begin
          nActV = 1'b0;
        end
      end else begin
        nCnt = wordCnt + 1'b1;
      end
    end
    if (stb.baseWr) begin
      if (!nActV) begin
        nActB = baseData;
        nActV = 1'b1;
        nCnt  = '0;
      end else begin
        nShB = baseData;
        nShV = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeValid <= 1'b0;
      shadowValid <= 1'b0;
      activeBase  <= '0;
      shadowBase  <= '0;
      wordCnt     <= '0;
    end else if (stb.clrAll) begin
      activeValid <= 1'b0;
      shadowValid <= 1'b0;
      activeBase  <= '0;
      shadowBase  <= '0;
      wordCnt     <= '0;
    end else begin
      activeValid <= nActV;
      shadowValid <= nShV;
      activeBase  <= nActB;
      shadowBase  <= nShB;
      wordCnt     <= nCnt;
    end
  end

  logic [OFS_W-1:0] unusedOfs;
  assign unusedOfs = {wordCnt, 2'b00};
endmodule

// File: rtl/capture_addr_ctrl.sv
module capture_addr_ctrl
  import capaddr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [3:0]        busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [4:0]        extEvt,
  input  logic              capValid,
  input  logic [DATA_W-1:0] capData,
  output logic              capReady,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memReady,
  output logic              irq
);
  dpStrobe_t         dpStb;
  logic [CNT_W-1:0]  sizeWords;
  logic [7:0]        statusReg, maskReg;
  logic              fillEvt, starveEvt;
  logic [ADDR_W-1:0] activeBase, shadowBase;
  logic [1:0]        flags;

  capaddr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .extEvt(extEvt),
    .fillEvt(fillEvt), .starveEvt(starveEvt), .activeBase(activeBase),
    .shadowBase(shadowBase), .curAddr(memAddr), .flags(flags),
    .stb(dpStb), .sizeWords(sizeWords), .statusReg(statusReg),
    .maskReg(maskReg), .irq(irq)
  );

  capaddr_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(dpStb), .baseData(busWrData[ADDR_W-1:0]),
    .sizeWords(sizeWords), .capValid(capValid), .capData(capData),
    .capReady(capReady), .memValid(memValid), .memAddr(memAddr),
    .memData(memData), .memReady(memReady), .fillEvt(fillEvt),
    .starveEvt(starveEvt), .activeBase(activeBase), .shadowBase(shadowBase),
    .flags(flags)
  );
endmodule

// File: rtl/capture_addr_ctrl_chk.sv
module capture_addr_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              capValid,
  input logic [DATA_W-1:0] capData,
  input logic              capReady,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic              memReady,
  input logic              fillEvt,
  input logic              clrAll,
  input logic              runBit,
  input logic [7:0]        statusReg
);
  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> capValid); // R11
  AST_DATA_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memData == capData)); // R11
  AST_READY_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rstN)
    capReady |-> memReady); // R11
  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> (!memValid && !capReady)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && !fillEvt && !clrAll) |=>
      (memAddr == $past(memAddr) + ADDR_W'(4))); // R2
  AST_FILL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (fillEvt && !clrAll) |=> (statusReg[7:6] == 2'b11)); // R1
endmodule

bind capture_addr_ctrl capture_addr_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .capValid(capValid), .capData(capData),
  .capReady(capReady), .memValid(memValid), .memAddr(memAddr),
  .memData(memData), .memReady(memReady), .fillEvt(fillEvt),
  .clrAll(dpStb.clrAll), .runBit(dpStb.run), .statusReg(statusReg)
);

// File: tb/sim_capture_addr_ctrl.sv
`timescale 1ns/100ps
module sim_capture_addr_ctrl;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [3:0]        busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [4:0]        extEvt = '0;
  logic              capValid = 1'b0;
  logic [DATA_W-1:0] capData = '0;
  logic              capReady, memValid, memReady, irq;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  capture_addr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .extEvt(extEvt),
    .capValid(capValid), .capData(capData), .capReady(capReady),
    .memValid(memValid), .memAddr(memAddr), .memData(memData),
    .memReady(memReady), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    busAddr = 4'(a); busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #0.5;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    busAddr = 4'(a);
    #0.2;
    v = busRdData;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    memReady = 1'b1;
    repeat (3) @(posedge clk);
    #0.5 rstN = 1'b1;
    @(posedge clk); #0.5;

    // R9 R8 reset state
    rd(4, v); chk("R9 status after reset", v, 0);
    rd(8, v); chk("R9 flags after reset", v, 0);
    chk("R7 irq after reset", 32'(irq), 0);
    capValid = 1'b1; #0.2;
    chk("R8 memValid idle", 32'(memValid), 0);
    chk("R8 capReady idle", 32'(capReady), 0);
    capValid = 1'b0;

    // R3 base then shadow
    wr(2, 32'h1230); wr(2, 32'h4560);
    rd(2, v); chk("R3 current base", v, 32'h1230);
    rd(7, v); chk("R3 shadow base", v, 32'h4560);
    rd(8, v); chk("R3 flags", v, 3);

    // R1 R2 R4 R5 R11 sweep over buffer lengths
    for (int s = 1; s <= 6; s++) begin
      logic [ADDR_W-1:0] baseA, baseB, baseD;
      int cnt, cyc;
      baseA = ADDR_W'(16'h0100 * s);
      baseB = ADDR_W'(16'h2000 + 16'h0040 * s);
      baseD = ADDR_W'(16'h7000 + 16'h0010 * s);
      wr(1, 32'h8000_0000);
      wr(3, 32'(s)); wr(2, 32'(baseA)); wr(2, 32'(baseB)); wr(0, 1);
      cnt = 0; cyc = 0;
      while (cnt < 2 * s && cyc < 200) begin
        capValid = 1'b1; capData = 32'hD000 + 32'(cnt);
        memReady = ((cyc % 3) != 1);
        #0.5;
        if (memValid && memReady) begin
          chk("R2 R4 address", 32'(memAddr),
              (cnt < s) ? 32'(baseA) + 32'(4 * cnt) : 32'(baseB) + 32'(4 * (cnt - s)));
          chk("R11 data", memData, 32'hD000 + 32'(cnt));
          cnt++;
        end
        @(posedge clk); #0.5;
        cyc++;
      end
      capValid = 1'b1; memReady = 1'b1; #0.2;
      chk("R5 stalled valid", 32'(memValid), 0);
      chk("R5 stalled ready", 32'(capReady), 0);
      rd(4, v); chk("R1 R5 status after two fills", v, 32'hE0);
      rd(8, v); chk("R4 flags after swap and stall", v, 0);
      wr(2, 32'(baseD));
      #0.2;
      chk("R5 resume valid", 32'(memValid), 1);
      chk("R5 resume address", 32'(memAddr), 32'(baseD));
      capValid = 1'b0;
    end

    // R6 write-one-to-clear and R7 mask
    wr(5, 32'h00);
    #0.2 chk("R7 irq masked", 32'(irq), 0);
    wr(5, 32'h20);
    #0.2 chk("R7 irq bit5", 32'(irq), 1);
    wr(4, 32'h40);
    rd(4, v); chk("R6 clear bit6 only", v, 32'hA0);
    wr(4, 32'h00);
    rd(4, v); chk("R6 zero write no effect", v, 32'hA0);
    wr(5, 32'h40);
    #0.2 chk("R7 irq bit6 not set", 32'(irq), 0);
    wr(5, 32'hFF);
    #0.2 chk("R7 irq all enabled", 32'(irq), 1);
    wr(4, 32'hFF);
    rd(4, v); chk("R6 clear all", v, 0);
    #0.2 chk("R7 irq after clear", 32'(irq), 0);

    // R10 external events
    for (int k = 0; k < 5; k++) begin
      extEvt = 5'(1 << k);
      @(posedge clk); #0.5;
      extEvt = '0;
      rd(4, v); chk("R10 event bit", v, 32'(1 << k));
      wr(4, 32'hFF);
    end

    // R8 run gating with a valid buffer
    wr(0, 0); capValid = 1'b1; #0.2;
    chk("R8 stopped valid", 32'(memValid), 0);
    wr(0, 1); #0.2;
    chk("R8 running valid", 32'(memValid), 1);
    capValid = 1'b0;

    // R9 soft reset
    wr(2, 32'h0ABC);
    extEvt = 5'h1; @(posedge clk); #0.5; extEvt = '0;
    wr(1, 32'h8000_0000);
    rd(4, v); chk("R9 status cleared", v, 0);
    rd(5, v); chk("R9 mask cleared", v, 0);
    rd(0, v); chk("R9 run cleared", v, 0);
    rd(8, v); chk("R9 flags cleared", v, 0);
    rd(3, v); chk("R9 size cleared", v, 0);
    rd(1, v); chk("R9 control reads zero", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end
endmodule